// File: doc/BRIEF.md
# Gated Three-Digit Decimal Frequency Meter

This block measures how many rising edges a digital input makes in one second and presents the result as three held BCD digits (hundreds, tens, ones), from 0 to 999. A binary time base divides the 32.768 kHz reference clock by 16384 and then by a further 4. This gives a gate that alternates between a one-second counting phase and a one-second rest phase.

In the counting phase, a chain of three decade counters counts the rising edges of the input after a two-flop synchroniser has brought it into the reference clock domain. The running count is copied into holding registers in the first cycle of the rest phase. The counters are cleared for the rest of that phase. The displayed digits therefore change only once per two-second cycle, and always show a complete one-second window. A count that would exceed 999 stops at 999 and raises an over-range flag. The flag is held with the digits.

The `PRESCALE_LOG2` parameter sets the first division stage. Lowering it shortens both phases in proportion, which is useful for a quick check. The seven-segment decoding, the oscillator and any input conditioning lie outside the block.

Top module: `decade_freq_meter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the time base, counters, held digits and over-range flag are cleared. In the first cycle after `rst` falls, `countPhase` is 1, all three digits read 0 and `overRange` is 0.
- R2: `countPhase` is 1 for exactly 2^(PRESCALE_LOG2+1) cycles and then 0 for the same number of cycles, repeating. With the default of 14, each phase is 32768 cycles, which is one second at 32.768 kHz.
- R3: The held value equals the number of rising edges of `sigIn` whose synchronised copy falls inside the counting phase. It is given as BCD: `onesBcd` holds units, `tensBcd` tens and `hundredsBcd` hundreds, each a 4-bit binary value of one decimal digit.
- R4: Rising edges of `sigIn` during the rest phase do not change the next held value.
- R5: The held outputs stay unchanged through the whole counting phase and through the first rest-phase cycle. The new value appears in the second rest-phase cycle and stays there until the next capture.
- R6: If a window contains more than 999 rising edges, the held digits read 9, 9, 9 and `overRange` is 1.
- R7: `overRange` is replaced at every capture. A window with 999 or fewer edges that follows an over-range window returns it to 0.
- R8: A window with exactly 999 edges reads 9, 9, 9 with `overRange` 0.
- R9: An input held at a constant level across a whole window, including a constant high level, gives a held value of 0.
- R10: No held digit ever exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sigIn | input | 1 | Signal whose frequency is measured; asynchronous |
| countPhase | output | 1 | 1 during the counting phase, 0 during the rest phase |
| onesBcd | output | 4 | Held units digit |
| tensBcd | output | 4 | Held tens digit |
| hundredsBcd | output | 4 | Held hundreds digit |
| overRange | output | 1 | Held flag: the last window counted past 999 |

## Verification
Saturation is the hardest case to reach from the ports. It needs more than 999 edges inside a single counting phase, and the synchroniser allows at most one edge every two cycles. The bench therefore sets `PRESCALE_LOG2` to 10, which gives a 2048-cycle phase. It then drives one-cycle pulses from the third cycle of the phase so that 1020 edges fit inside the window. The bench counts cycles from the release of reset to align every burst with the gate. Rest-phase noise bursts and a window with the input held high show that only in-window edges are counted.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
  localparam int NUM_DIGITS = 3;
  localparam int BCD_W      = 4;

  // Strobes from the time base to the counting datapath
  typedef struct packed {
    logic countEn;   // counting phase: accept rising edges
    logic capture;   // first rest cycle: copy count into hold registers
    logic clear;     // remaining rest cycles: zero the counters
  } gateStrobes_t;
endpackage

// File: rtl/fcnt_timebase.sv
module fcnt_timebase
  import fcnt_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 14
) (
  input  logic         clk,
  input  logic         rst,
  output gateStrobes_t strb,
  output logic         countPhase
);
  // prescale stage plus a further divide by four; top bit is the gate
  localparam int TB_W = PRESCALE_LOG2 + 2;
  localparam logic [TB_W-1:0] HALF = {1'b1, {(TB_W-1){1'b0}}};

  logic [TB_W-1:0] tbCnt;
  logic            gateRest;

  always_ff @(posedge clk) begin
    if (rst) tbCnt <= '0;
    else     tbCnt <= tbCnt + 1'b1;
  end

  always_comb begin
    gateRest     = tbCnt[TB_W-1];
    countPhase   = ~gateRest;
    strb.countEn = ~gateRest;
    strb.capture = (tbCnt == HALF);
    strb.clear   = gateRest & ~strb.capture;
  end

  // R5: the end of counting is always followed by capture in the same cycle
  end_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strb.countEn) |-> strb.capture);

  // R5: capture is followed by clearing, never by counting
  capture_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> (strb.clear && !strb.countEn));

  // R2: at most one strobe active at a time
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.countEn, strb.capture, strb.clear}));
endmodule

// File: rtl/fcnt_datapath.sv
module fcnt_datapath
  import fcnt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sigIn,
  input  gateStrobes_t                  strb,
  output logic [NUM_DIGITS*BCD_W-1:0]   heldFlat,
  output logic                          heldOvf
);
  localparam logic [BCD_W-1:0] NINE = BCD_W'(9);

  logic [1:0] syncQ;
  logic       prevLvl;
  logic       riseEv;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], sigIn};
      prevLvl <= syncQ[1];
    end
  end

  assign riseEv = syncQ[1] & ~prevLvl;

  logic [BCD_W-1:0]    cnt  [NUM_DIGITS];
  logic [BCD_W-1:0]    held [NUM_DIGITS];
  logic [NUM_DIGITS-1:0] isNine;
  logic [NUM_DIGITS:0]   carry;
  logic                allNine;
  logic                ovfRun;

  assign allNine  = &isNine;
  assign carry[0] = riseEv & strb.countEn & ~allNine;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign isNine[i]  = (cnt[i] == NINE);
    assign carry[i+1] = carry[i] & isNine[i];

    always_ff @(posedge clk) begin
      if (rst || strb.clear)  cnt[i] <= '0;
      else if (carry[i])      cnt[i] <= isNine[i] ? '0 : cnt[i] + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)               held[i] <= '0;
      else if (strb.capture) held[i] <= cnt[i];
    end

    assign heldFlat[i*BCD_W +: BCD_W] = held[i];

    // R10
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] <= NINE) && (held[i] <= NINE));

    // R4
    cleared_zero_chk: assert property (@(posedge clk) disable iff (rst)
      strb.clear |=> (cnt[i] == '0));
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear)                    ovfRun <= 1'b0;
    else if (riseEv && strb.countEn && allNine) ovfRun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               heldOvf <= 1'b0;
    else if (strb.capture) heldOvf <= ovfRun;
  end

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ovfRun |-> allNine);

  // R5
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> ($stable(heldFlat) && $stable(heldOvf)));
endmodule

// File: rtl/decade_freq_meter.sv
module decade_freq_meter
  import fcnt_pkg::*;
#(
  parameter int PRESCALE_LOG2 = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sigIn,
  output logic       countPhase,
  output logic [3:0] onesBcd,
  output logic [3:0] tensBcd,
  output logic [3:0] hundredsBcd,
  output logic       overRange
);
  gateStrobes_t                 strb;
  logic [NUM_DIGITS*BCD_W-1:0]  heldFlat;

  fcnt_timebase #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .countPhase (countPhase)
  );

  fcnt_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .sigIn    (sigIn),
    .strb     (strb),
    .heldFlat (heldFlat),
    .heldOvf  (overRange)
  );

  assign onesBcd     = heldFlat[3:0];
  assign tensBcd     = heldFlat[7:4];
  assign hundredsBcd = heldFlat[11:8];
endmodule

// File: tb/decade_freq_meter_test.sv
module decade_freq_meter_test;
  localparam int PL2  = 10;
  localparam int HALF = 1 << (PL2 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sigIn = 1'b0;
  logic countPhase, overRange;
  logic [3:0] onesBcd, tensBcd, hundredsBcd;

  int nChecks = 0;
  int nFails  = 0;
  int prevVal = 0;
  bit prevOvf = 1'b0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  decade_freq_meter #(.PRESCALE_LOG2(PL2)) uut (
    .clk(clk), .rst(rst), .sigIn(sigIn), .countPhase(countPhase),
    .onesBcd(onesBcd), .tensBcd(tensBcd), .hundredsBcd(hundredsBcd),
    .overRange(overRange)
  );

  function automatic int satCount(int n);
    return (n > 999) ? 999 : n;
  endfunction

  function automatic logic [12:0] packExp(int v, bit ovf);
    return {ovf, 4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkHeld(string tag, int v, bit ovf);
    logic [12:0] act, exp;
    act = {overRange, hundredsBcd, tensBcd, onesBcd};
    exp = packExp(v, ovf);
    check(act == exp, tag, int'(act), int'(exp));
    // R10: every held digit is a decimal digit
    check(onesBcd <= 9 && tensBcd <= 9 && hundredsBcd <= 9, "R10 digit range",
          int'(act), int'(exp));
  endtask

  // Entered at the negedge of the first counting cycle (t=0).
  task automatic runWindow(int n, bit noise, bit restLevel, string tag);
    int cyc, gap, maxGap, cycLow, expVal;
    bit expOvf;
    cyc = 0;
    if (n > 0) sigIn = 1'b0;
    @(negedge clk); cyc++;
    @(negedge clk); cyc++;
    maxGap = (n == 0) ? 2 : 2040 / n;
    if (maxGap < 2) maxGap = 2;
    gap = 2 + int'($urandom % (maxGap - 1));
    for (int i = 0; i < n; i++) begin
      sigIn = 1'b1;
      @(negedge clk); cyc++;
      sigIn = 1'b0;
      repeat (gap - 1) begin @(negedge clk); cyc++; end
    end
    while (countPhase) begin @(negedge clk); cyc++; end
    // R2: counting phase length
    check(cyc == HALF, "R2 count phase length", cyc, HALF);
    // R5: first rest cycle still shows the previous result
    checkHeld("R5 held before update", prevVal, prevOvf);
    expVal = satCount(n);
    expOvf = (n > 999);
    cycLow = 0;
    @(negedge clk); cycLow++;
    checkHeld(tag, expVal, expOvf);
    prevVal = expVal;
    prevOvf = expOvf;
    while (!countPhase) begin
      if (cycLow >= HALF - 16)                         sigIn = restLevel;
      else if (noise && (cycLow % 4 == 1))             sigIn = 1'b1;
      else                                             sigIn = 1'b0;
      @(negedge clk); cycLow++;
    end
    // R2: rest phase length
    check(cycLow == HALF, "R2 rest phase length", cycLow, HALF);
  endtask

  initial begin
    int seedDummy, n;
    seedDummy = int'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset release
    check(countPhase == 1'b1, "R1 countPhase after reset", countPhase, 1);
    checkHeld("R1 held after reset", 0, 1'b0);
    runWindow(123,  1'b0, 1'b0, "R3 123 edges");
    runWindow(7,    1'b1, 1'b0, "R4 rest-phase noise ignored");
    runWindow(0,    1'b1, 1'b1, "R4 zero after noisy rest");
    runWindow(0,    1'b0, 1'b0, "R9 constant high level");
    runWindow(999,  1'b0, 1'b0, "R8 exactly 999");
    runWindow(1020, 1'b0, 1'b0, "R6 saturation and flag");
    runWindow(58,   1'b1, 1'b0, "R7 flag cleared next capture");
    runWindow(1000, 1'b0, 1'b0, "R6 1000 edges");
    for (int k = 0; k < 6; k++) begin
      n = int'($urandom % 1021);
      runWindow(n, k[0], 1'b0, "R3 random rate");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule